// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This unit sits beside a processor core. It owns the processor status word, the cause register and two pairs of save registers: one pair for maskable interrupts and one for the non-maskable interrupt (NMI). On every cycle it decides what to do next. It can leave reset, take a pending NMI, take one of six maskable requests, or carry out a return-from-interrupt. When it does any of these, it emits a one-cycle redirect pulse with the address the core should fetch next.

The core supplies the address of the next instruction it would have executed. That address is what gets saved on entry. The core raises a single-cycle return strobe when it executes a return instruction. The sequencer then chooses which save pair to restore from by looking at the status flags, and it redirects to the saved address with bit 0 forced to zero.

An NMI that arrives while another NMI is still being serviced is not lost. It is recorded as a single pending request and taken as soon as the in-progress flag clears. Any further NMIs in that window merge into the same request.

Top module: `exc_sequencer`

## Requirements
- R1: While reset is asserted, the status word holds 0x20 and the cause register, all save registers and the redirect pulse hold 0. In the first cycle after reset is released, a redirect to address 0 is issued and nothing else is taken.
- R2: A rising edge on the NMI input while the status word's NMI-in-progress bit (bit 7) is set produces no redirect. It is held as one pending request and taken in the first cycle in which bit 7 is clear. Any number of extra edges in that window produce only one later entry.
- R3: NMI entry saves the next address into the NMI save address and the status word into the NMI save status. It sets bit 7 and the disable bit (bit 5), clears the exception-pending bit (bit 6), and redirects to 0x10.
- R4: Maskable requests are level inputs. They produce no redirect while status bit 7 or bit 5 is set, and they are taken once both bits are clear, provided the request is still held.
- R5: Maskable entry saves the next address and the status word as it was before masking. It then sets bit 5 and clears bit 6.
- R6: A maskable entry replaces cause bits 15:0 with the vector code and leaves bits 31:16 unchanged. An NMI entry writes 0x0010 into cause bits 31:16 and leaves bits 15:0 unchanged.
- R7: Request line i (0 to 5) vectors to 0x80 + 0x10*i, and that value is also its cause code. When several lines are high at once, the lowest index wins.
- R8: On a return strobe, the unit restores from the maskable pair if status bit 6 is set. Otherwise it restores from the NMI pair if bit 7 is set. Otherwise it restores from the maskable pair. The chosen save status is loaded into the status word.
- R9: The return redirect target is the saved address with bit 0 cleared and no other adjustment.
- R10: In a cycle with a return strobe, no entry is taken. Pending requests are evaluated in the next cycle against the restored status word.
- R11: Priority runs reset-exit first, then NMI, then maskable. An NMI and a maskable request arriving in the same allowed cycle produce an NMI entry only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | NMI request; its rising edge raises the request |
| irq_req | input | 6 | Level-held maskable requests, index 0 has highest priority |
| next_pc | input | 32 | Address of the next instruction to execute |
| ret_strobe | input | 1 | One-cycle return-from-interrupt strobe |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Redirect target address |
| psw | output | 32 | Status word (bit 5 disable, bit 6 exception pending, bit 7 NMI in progress) |
| cause | output | 32 | Cause register |
| int_pc | output | 32 | Maskable save address |
| int_psw | output | 32 | Maskable save status |
| nmi_pc | output | 32 | NMI save address |
| nmi_psw | output | 32 | NMI save status |

## Verification
A corrupted status flag appears on the very next redirect. If the disable or NMI-in-progress bit is wrong, a request is taken when it should not be, or is withheld when it should be taken, and this shows within one cycle of the request. If the pending NMI flag is wrong, an NMI goes missing or an extra one appears in the cycle right after a return. That is why the bench checks for a second redirect in the cycles that follow. If a save register was written with the wrong status word, the error stays hidden until the matching return, when it appears as a wrong restored status word and a wrong target.

// File: rtl/exc_sequencer.sv
module exc_sequencer #(
  parameter int XLEN = 32,
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_req,
  input  logic [NSRC-1:0] irq_req,
  input  logic [XLEN-1:0] next_pc,
  input  logic            ret_strobe,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic [XLEN-1:0] psw,
  output logic [XLEN-1:0] cause,
  output logic [XLEN-1:0] int_pc,
  output logic [XLEN-1:0] int_psw,
  output logic [XLEN-1:0] nmi_pc,
  output logic [XLEN-1:0] nmi_psw
);
  localparam int ID_B = 5;
  localparam int EP_B = 6;
  localparam int NP_B = 7;
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [15:0] NMI_CODE = 16'h0010;
  localparam logic [15:0] VEC_BASE = 16'h0080;
  localparam logic [15:0] VEC_STEP = 16'h0010;
  localparam logic [XLEN-1:0] PSW_RST = XLEN'(32'h20);

  logic boot, nmi_q, nmi_pend;
  logic [IW-1:0] sel;
  logic [15:0] code;

  wire nmi_rise = nmi_req & ~nmi_q;
  wire nmi_go   = ~boot & ~ret_strobe & (nmi_pend | nmi_rise) & ~psw[NP_B];
  wire irq_go   = ~boot & ~ret_strobe & ~nmi_go & (|irq_req) & ~psw[NP_B] & ~psw[ID_B];
  wire from_int = psw[EP_B] | ~psw[NP_B];
  wire [XLEN-1:0] ret_pc  = from_int ? int_pc : nmi_pc;
  wire [XLEN-1:0] ret_psw = from_int ? int_psw : nmi_psw;

  always_comb begin
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (irq_req[i]) sel = IW'(i);
  end

  assign code = VEC_BASE + VEC_STEP * 16'(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot        <= 1'b1;
      nmi_q       <= 1'b0;
      nmi_pend    <= 1'b0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      psw         <= PSW_RST;
      cause       <= '0;
      int_pc      <= '0;
      int_psw     <= '0;
      nmi_pc      <= '0;
      nmi_psw     <= '0;
    end else begin
      nmi_q       <= nmi_req;
      redir_valid <= 1'b0;
      if (nmi_go)        nmi_pend <= 1'b0;
      else if (nmi_rise) nmi_pend <= 1'b1;

      if (boot) begin
        boot        <= 1'b0;
        redir_valid <= 1'b1;
        redir_pc    <= '0;
      end else if (ret_strobe) begin
        redir_valid <= 1'b1;
        redir_pc    <= ret_pc & ~XLEN'(1);
        psw         <= ret_psw;
      end else if (nmi_go) begin
        nmi_pc        <= next_pc;
        nmi_psw       <= psw;
        cause[31:16]  <= NMI_CODE;
        psw[NP_B]     <= 1'b1;
        psw[ID_B]     <= 1'b1;
        psw[EP_B]     <= 1'b0;
        redir_valid   <= 1'b1;
        redir_pc      <= XLEN'(NMI_CODE);
      end else if (irq_go) begin
        int_pc        <= next_pc;
        int_psw       <= psw;
        cause[15:0]   <= code;
        psw[ID_B]     <= 1'b1;
        psw[EP_B]     <= 1'b0;
        redir_valid   <= 1'b1;
        redir_pc      <= XLEN'(code);
      end
    end
  end
endmodule

// File: rtl/exc_sequencer_chk.sv
module exc_sequencer_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ret_strobe,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_pc,
  input logic            psw_id,
  input logic            psw_ep,
  input logic            psw_np,
  input logic            ipsw_id,
  input logic            ipsw_np,
  input logic [31:0]     cause
);
  logic ret_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ret_d <= 1'b0;
    else        ret_d <= ret_strobe;

  // R3
  nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !ret_d && redir_pc == XLEN'(32'h10)) |->
      (psw_np && psw_id && !psw_ep && cause[31:16] == 16'h0010));

  // R5
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !ret_d && redir_pc[7]) |->
      (!ipsw_id && !ipsw_np && psw_id && !psw_ep && cause[15:0] == redir_pc[15:0]));

  // R9
  ret_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && ret_d) |-> !redir_pc[0]);

  // R4
  irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((psw_np || psw_id) && !ret_strobe) |=> !(redir_valid && !ret_d && redir_pc[7]));

  // R2
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_np && !ret_strobe) |=> !(redir_valid && !ret_d && redir_pc == XLEN'(32'h10)));
endmodule

bind exc_sequencer exc_sequencer_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_strobe(ret_strobe),
  .redir_valid(redir_valid), .redir_pc(redir_pc),
  .psw_id(psw[5]), .psw_ep(psw[6]), .psw_np(psw[7]),
  .ipsw_id(int_psw[5]), .ipsw_np(int_psw[7]), .cause(cause[31:0])
);

// File: tb/exc_sequencer_test.sv
module exc_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_req = 1'b0;
  logic [5:0]  irq_req = '0;
  logic [31:0] next_pc = '0;
  logic        ret_strobe = 1'b0;
  logic        redir_valid;
  logic [31:0] redir_pc, psw, cause, int_pc, int_psw, nmi_pc, nmi_psw;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
    .next_pc(next_pc), .ret_strobe(ret_strobe), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .psw(psw), .cause(cause), .int_pc(int_pc),
    .int_psw(int_psw), .nmi_pc(nmi_pc), .nmi_psw(nmi_psw)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic redirect(input string req, input logic [31:0] pc);
    chk({req, " valid"}, 32'(redir_valid), 32'd1);
    chk({req, " target"}, redir_pc, pc);
  endtask

  task automatic t_reset();
    chk("R1 psw in reset", psw, 32'h20);
    chk("R1 cause in reset", cause, 32'h0);
    chk("R1 no redirect in reset", 32'(redir_valid), 32'd0);
    rst_n = 1'b1;
    step();
    redirect("R1 boot", 32'h0);
    step();
    chk("R1 single pulse", 32'(redir_valid), 32'd0);
  endtask

  task automatic t_blocked();
    irq_req = 6'b000001;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R4 blocked by disable", 32'(redir_valid), 32'd0);
    end
    chk("R4 save untouched", int_pc, 32'h0);
    irq_req = '0;
  endtask

  task automatic t_ret_plain();
    ret_strobe = 1'b1;
    step();
    ret_strobe = 1'b0;
    redirect("R8 no-flag return", 32'h0);
    chk("R8 psw restored", psw, 32'h0);
  endtask

  task automatic t_irq_take();
    next_pc = 32'h1234;
    irq_req = 6'b001100;
    step();
    irq_req = '0;
    redirect("R7 lowest index", 32'hA0);
    chk("R5 save pc", int_pc, 32'h1234);
    chk("R5 saved psw pre-mask", int_psw, 32'h0);
    chk("R5 psw masked", psw, 32'h20);
    chk("R6 cause low", cause, 32'h000000A0);
    step();
    chk("R4 pulse ends", 32'(redir_valid), 32'd0);
  endtask

  task automatic t_nmi_take();
    next_pc = 32'h2000;
    nmi_req = 1'b1;
    step();
    nmi_req = 1'b0;
    redirect("R3 nmi", 32'h10);
    chk("R3 save pc", nmi_pc, 32'h2000);
    chk("R3 save psw", nmi_psw, 32'h20);
    chk("R3 psw", psw, 32'hA0);
    chk("R6 cause high", cause, 32'h001000A0);
  endtask

  task automatic t_nmi_nested();
    irq_req = 6'b100000;
    for (int k = 0; k < 2; k++) begin
      nmi_req = 1'b1;
      step();
      nmi_req = 1'b0;
      chk("R2 nested nmi held", 32'(redir_valid), 32'd0);
      step();
      chk("R2 nested nmi held", 32'(redir_valid), 32'd0);
    end
    next_pc = 32'h3001;
    ret_strobe = 1'b1;
    step();
    ret_strobe = 1'b0;
    redirect("R8 nmi return", 32'h2000);
    chk("R8 psw from nmi pair", psw, 32'h20);
    step();
    redirect("R2 pending nmi", 32'h10);
    chk("R2 pending save pc", nmi_pc, 32'h3001);
    chk("R2 psw", psw, 32'hA0);
    step();
    chk("R4 blocked under nmi", 32'(redir_valid), 32'd0);
    ret_strobe = 1'b1;
    step();
    ret_strobe = 1'b0;
    redirect("R9 bit0 cleared", 32'h3000);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R2 collapsed", 32'(redir_valid), 32'd0);
    end
  endtask

  task automatic t_ret_then_irq();
    next_pc = 32'h4444;
    ret_strobe = 1'b1;
    step();
    ret_strobe = 1'b0;
    redirect("R10 return wins", 32'h1234);
    chk("R8 psw from int pair", psw, 32'h0);
    step();
    irq_req = '0;
    redirect("R10 irq next cycle", 32'hD0);
    chk("R5 save pc", int_pc, 32'h4444);
    chk("R6 cause keeps high", cause, 32'h001000D0);
  endtask

  task automatic t_priority();
    ret_strobe = 1'b1;
    step();
    ret_strobe = 1'b0;
    redirect("R8 return", 32'h4444);
    irq_req = 6'b000010;
    nmi_req = 1'b1;
    next_pc = 32'h5000;
    step();
    nmi_req = 1'b0;
    irq_req = '0;
    redirect("R11 nmi over irq", 32'h10);
    chk("R11 int save untouched", int_pc, 32'h4444);
    chk("R11 cause", cause, 32'h001000D0);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    t_blocked();
    t_ret_plain();
    t_irq_take();
    t_nmi_take();
    t_nmi_nested();
    t_ret_then_irq();
    t_priority();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule